// File: doc/BRIEF.md
# Interleaved Multi-Bank Word Memory Controller

This block is a word-addressed memory that sits behind a single processor-side request port. Inside it are several independent banks. Each bank is a synchronous array with a fixed access latency, its own latched row address and its own output data register. A flat word address is split into a bank number and a row within that bank. A mode input picks one of two splits. In linear mode, neighbouring words share a bank. In interleaved mode, neighbouring words rotate across the banks.

A read request carries a start address and a burst length of one to eight words. The controller sends at most one word per cycle to the banks, strictly in address order. It holds back whenever the next word's bank still has a word in flight or undelivered. The words come back to the processor in address order, one per cycle at most, and each comes with a completion strobe. In interleaved mode a sequential burst therefore keeps several banks busy at once and finishes much sooner than in linear mode.

A write request stores one word and raises the completion strobe once the target bank has taken it. A new request is only taken while the controller is idle.

Top module: `ilv_mem_ctrl`

## Requirements
- R1: With `ilv_mode`=1 sampled at acceptance, word address A maps to bank A[1:0] and row A[9:2].
- R2: With `ilv_mode`=0 sampled at acceptance, word address A maps to bank A[9:8] and row A[7:0].
- R3: The mapping mode and the request fields are captured at acceptance. Changing `ilv_mode` or the request inputs while an operation is in progress has no effect on that operation.
- R4: The words of a read burst are delivered in ascending address order. Each word is presented on `rdata` during a cycle in which `xfer_done` is high, and `xfer_done` is high for at most one word per cycle.
- R5: Word i of a read burst is sent to its bank no earlier than one cycle after word i-1, and the first word is sent at the first clock edge after acceptance. A word sent at clock edge e is delivered no sooner than the cycle that ends at edge e+5. An eight-word interleaved burst at a bank-aligned start therefore gives its last strobe in the cycle that ends 15 edges after acceptance.
- R6: A word is not sent to a bank that holds an in-flight or undelivered word. The bank can take a new word at the edge after its held word is delivered. An eight-word linear burst therefore ends 48 edges after acceptance.
- R7: A write is accepted into its bank in the cycle right after acceptance. `xfer_done` is high for exactly that one cycle, and the stored word is returned by later reads.
- R8: `req_ready` is high only while the controller is idle. A `req_valid` presented while `req_ready` is low is ignored.
- R9: `req_len` holds the burst length minus one, so the values 0 to 7 request 1 to 8 words.
- R10: Burst addresses wrap modulo 1024, so the word after address 1023 is address 0.
- R11: After reset, `req_ready` is 1 and `xfer_done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ilv_mode | input | 1 | 1 = interleaved mapping, 0 = linear mapping |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = single-word write, 0 = burst read |
| req_addr | input | 10 | Flat word address (start address for reads) |
| req_len | input | 3 | Burst length minus one (reads) |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Controller idle, request may be taken |
| xfer_done | output | 1 | Completion strobe, one per word |
| rdata | output | 16 | Read word, valid while `xfer_done` is high on a read |

## Verification
The bench goes after the timing of back-to-back words. A controller that ignored a busy bank would return stale or overwritten words in a linear burst. A controller that reused a bank one cycle too early or too late would shift the strobe cycles, so an aligned interleaved burst would no longer end exactly 15 edges after acceptance, or a linear one exactly 48. Unaligned and wrapping bursts catch a bank or row split taken from the wrong address bits: the wrong word would appear at the right time. A mode flip in mid-burst, and a request pulsed while the controller is busy, expose a design that samples its inputs after acceptance.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_READ  = 2'd1,
      ST_WRITE = 2'd2
   } seq_state_e;
endpackage

// File: rtl/ilv_addr_map.sv
// Splits a flat word address into a bank index and an in-bank row.
module ilv_addr_map #(
   parameter int AW = 10,
   parameter int BW = 2
) (
   input  logic          interleave,
   input  logic [AW-1:0] addr,
   output logic [BW-1:0] bank,
   output logic [AW-BW-1:0] row
);
   localparam int RW = AW - BW;

   always_comb begin
      if (interleave) begin
         bank = addr[BW-1:0];
         row  = addr[AW-1:BW];
      end else begin
         bank = addr[AW-1:RW];
         row  = addr[RW-1:0];
      end
   end
endmodule

// File: rtl/ilv_bank.sv
// One memory bank: latched row register, latency counter, output data register.
module ilv_bank #(
   parameter int DW  = 16,
   parameter int RW  = 8,
   parameter int LAT = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_issue,
   input  logic          wr_en,
   input  logic [RW-1:0] row_in,
   input  logic [DW-1:0] wdata,
   input  logic          free,
   output logic          busy,
   output logic          dvalid,
   output logic [RW-1:0] held_row,
   output logic [DW-1:0] dbr
);
   localparam int DEPTH = 1 << RW;
   localparam int CW    = (LAT > 1) ? $clog2(LAT) : 1;

   logic [DW-1:0] mem [DEPTH];
   logic [RW-1:0] abr;
   logic [CW-1:0] cnt;
   logic          active;

   always_ff @(posedge clk) begin
      if (wr_en) mem[row_in] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         abr    <= '0;
         cnt    <= '0;
         active <= 1'b0;
         dvalid <= 1'b0;
         dbr    <= '0;
      end else begin
         if (rd_issue) begin
            abr    <= row_in;
            active <= 1'b1;
            cnt    <= CW'(LAT - 1);
         end else if (active) begin
            if (cnt != '0) begin
               cnt <= cnt - 1'b1;
            end else begin
               dbr    <= mem[abr];
               dvalid <= 1'b1;
               active <= 1'b0;
            end
         end
         if (free) dvalid <= 1'b0;
      end
   end

   assign busy     = active | dvalid;
   assign held_row = abr;

   a_r6_issue_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
      rd_issue |-> !busy);
   a_r6_free_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
      free |-> dvalid);
   a_r4_dbr_held: assert property (@(posedge clk) disable iff (!rst_n)
      (dvalid && !free) |=> (dvalid && $stable(dbr)));
endmodule

// File: rtl/ilv_seq.sv
// Request sequencer: in-order issue with per-bank stall, in-order delivery.
module ilv_seq
   import ilv_pkg::*;
#(
   parameter int AW = 10,
   parameter int BW = 2,
   parameter int DW = 16,
   parameter int LW = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ilv_mode,
   input  logic                  req_valid,
   input  logic                  req_write,
   input  logic [AW-1:0]         req_addr,
   input  logic [LW-1:0]         req_len,
   input  logic [DW-1:0]         req_wdata,
   input  logic [(1<<BW)-1:0]    bank_busy,
   input  logic [(1<<BW)-1:0]    bank_dv,
   input  logic [(1<<BW)-1:0][AW-BW-1:0] bank_row,
   input  logic [(1<<BW)-1:0][DW-1:0]    bank_dbr,
   output logic                  req_ready,
   output logic                  xfer_done,
   output logic [DW-1:0]         rdata,
   output logic [(1<<BW)-1:0]    rd_issue_vec,
   output logic [(1<<BW)-1:0]    wr_vec,
   output logic [(1<<BW)-1:0]    free_vec,
   output logic [AW-BW-1:0]      row_out,
   output logic [DW-1:0]         wdata_out
);
   localparam int NB = 1 << BW;
   localparam int RW = AW - BW;

   seq_state_e    state;
   logic          mode_q;
   logic [AW-1:0] base_q;
   logic [LW:0]   len_q, iss_idx, dlv_idx;
   logic [DW-1:0] wdata_q;

   logic [AW-1:0] iss_addr, dlv_addr;
   logic [BW-1:0] ib, db;
   logic [RW-1:0] ir, dr;
   logic          issue_ok, dlv_ok;

   assign iss_addr = base_q + AW'(iss_idx);
   assign dlv_addr = base_q + AW'(dlv_idx);

   ilv_addr_map #(.AW(AW), .BW(BW)) u_map_iss (
      .interleave(mode_q), .addr(iss_addr), .bank(ib), .row(ir));
   ilv_addr_map #(.AW(AW), .BW(BW)) u_map_dlv (
      .interleave(mode_q), .addr(dlv_addr), .bank(db), .row(dr));

   always_comb begin
      issue_ok     = (state == ST_READ) && (iss_idx < len_q) && !bank_busy[ib];
      dlv_ok       = (state == ST_READ) && bank_dv[db];
      rd_issue_vec = issue_ok ? (NB'(1) << ib) : '0;
      wr_vec       = (state == ST_WRITE) ? (NB'(1) << ib) : '0;
      free_vec     = dlv_ok ? (NB'(1) << db) : '0;
      xfer_done    = dlv_ok || (state == ST_WRITE);
      rdata        = dlv_ok ? bank_dbr[db] : '0;
      row_out      = ir;
      wdata_out    = wdata_q;
      req_ready    = (state == ST_IDLE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         mode_q  <= 1'b0;
         base_q  <= '0;
         len_q   <= '0;
         iss_idx <= '0;
         dlv_idx <= '0;
         wdata_q <= '0;
      end else begin
         unique case (state)
            ST_IDLE: if (req_valid) begin
               mode_q  <= ilv_mode;
               base_q  <= req_addr;
               wdata_q <= req_wdata;
               len_q   <= {1'b0, req_len} + 1'b1;
               iss_idx <= '0;
               dlv_idx <= '0;
               state   <= req_write ? ST_WRITE : ST_READ;
            end
            ST_READ: begin
               if (issue_ok) iss_idx <= iss_idx + 1'b1;
               if (dlv_ok) begin
                  dlv_idx <= dlv_idx + 1'b1;
                  if ((dlv_idx + 1'b1) == len_q) state <= ST_IDLE;
               end
            end
            ST_WRITE: state <= ST_IDLE;
            default:  state <= ST_IDLE;
         endcase
      end
   end

   a_r6_one_issue: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rd_issue_vec | wr_vec));
   a_r4_issued_first: assert property (@(posedge clk) disable iff (!rst_n)
      dlv_ok |-> (dlv_idx < iss_idx));
   a_r4_row_match: assert property (@(posedge clk) disable iff (!rst_n)
      dlv_ok |-> (bank_row[db] == dr));
   a_r9_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_READ) |-> (dlv_idx < len_q && iss_idx <= len_q));
   a_r3_fields_held: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_IDLE) |=> ($stable(mode_q) && $stable(base_q) && $stable(len_q)));
   a_r7_write_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WRITE) |=> (state == ST_IDLE));
endmodule

// File: rtl/ilv_mem_ctrl.sv
module ilv_mem_ctrl #(
   parameter int NBANK  = 4,
   parameter int DW     = 16,
   parameter int AW     = 10,
   parameter int LAT    = 4,
   parameter int MAXLEN = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       ilv_mode,
   input  logic                       req_valid,
   input  logic                       req_write,
   input  logic [AW-1:0]              req_addr,
   input  logic [$clog2(MAXLEN)-1:0]  req_len,
   input  logic [DW-1:0]              req_wdata,
   output logic                       req_ready,
   output logic                       xfer_done,
   output logic [DW-1:0]              rdata
);
   localparam int BW = $clog2(NBANK);
   localparam int RW = AW - BW;
   localparam int LW = $clog2(MAXLEN);

   initial begin
      a_cfg_banks: assert (NBANK >= 2 && (1 << BW) == NBANK)
         else $error("NBANK must be a power of two, at least 2");
      a_cfg_len: assert (MAXLEN >= 2 && (1 << LW) == MAXLEN)
         else $error("MAXLEN must be a power of two, at least 2");
      a_cfg_lat: assert (LAT >= 1) else $error("LAT must be at least 1");
      a_cfg_addr: assert (AW > BW) else $error("AW must exceed bank bits");
   end

   logic [NBANK-1:0]          busy, dv, rd_issue_vec, wr_vec, free_vec;
   logic [NBANK-1:0][RW-1:0]  held_row;
   logic [NBANK-1:0][DW-1:0]  dbr_all;
   logic [RW-1:0]             row_out;
   logic [DW-1:0]             wdata_out;

   ilv_seq #(.AW(AW), .BW(BW), .DW(DW), .LW(LW)) u_seq (
      .clk, .rst_n, .ilv_mode, .req_valid, .req_write, .req_addr, .req_len,
      .req_wdata, .bank_busy(busy), .bank_dv(dv), .bank_row(held_row),
      .bank_dbr(dbr_all), .req_ready, .xfer_done, .rdata,
      .rd_issue_vec, .wr_vec, .free_vec, .row_out, .wdata_out);

   for (genvar g = 0; g < NBANK; g++) begin : g_bank
      ilv_bank #(.DW(DW), .RW(RW), .LAT(LAT)) u_bank (
         .clk, .rst_n,
         .rd_issue(rd_issue_vec[g]), .wr_en(wr_vec[g]),
         .row_in(row_out), .wdata(wdata_out), .free(free_vec[g]),
         .busy(busy[g]), .dvalid(dv[g]), .held_row(held_row[g]),
         .dbr(dbr_all[g]));
   end

   a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (busy == '0));
   a_r4_one_deliver: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(free_vec));
endmodule

// File: tb/tb_ilv_mem_ctrl.sv
module tb_ilv_mem_ctrl;
   localparam realtime HALF = 2.5ns;

   logic clk = 1'b0, rst_n = 1'b0;
   logic ilv_mode = 1'b0, req_valid = 1'b0, req_write = 1'b0;
   logic [9:0]  req_addr = '0;
   logic [2:0]  req_len = '0;
   logic [15:0] req_wdata = '0;
   logic        req_ready, xfer_done;
   logic [15:0] rdata;

   ilv_mem_ctrl dut (.*);

   always #HALF clk = ~clk;

   typedef struct { int edge_n; bit is_rd; logic [15:0] data; string tag; } exp_t;
   exp_t expq[$];
   logic [15:0] mref [0:3][0:255];
   int cyc = 0, checks = 0, errors = 0, last_done = 0;
   bit run = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   function automatic int bank_of(bit m, int a);
      return m ? (a % 4) : (a / 256);
   endfunction
   function automatic int row_of(bit m, int a);
      return m ? (a / 4) : (a % 256);
   endfunction

   // per-clock comparison against the expected completion stream
   always @(negedge clk) begin
      if (run) begin
         if (expq.size() != 0 && expq[0].edge_n - 1 == cyc) begin
            chk({expq[0].tag, " strobe"}, xfer_done, 1);
            if (expq[0].is_rd) chk({expq[0].tag, " data"}, rdata, expq[0].data);
            last_done = cyc + 1;
            void'(expq.pop_front());
         end else begin
            chk("R4 no strobe expected", xfer_done, 0);
         end
      end
   end

   task automatic wait_ready();
      @(negedge clk);
      while (!req_ready) @(negedge clk);
   endtask

   task automatic do_write(bit m, int a, logic [15:0] d);
      int acc;
      wait_ready();
      acc = cyc + 1;
      mref[bank_of(m, a)][row_of(m, a)] = d;
      expq.push_back('{acc + 1, 1'b0, 16'h0, "R7 write"});
      ilv_mode = m; req_write = 1; req_addr = 10'(a); req_wdata = d; req_valid = 1;
      @(negedge clk);
      req_valid = 0;
   endtask

   // timing model: in-order issue, one per cycle, bank reusable after delivery
   task automatic do_read(bit m, int start, int len, output int acc);
      int bank_d[4];
      int pe, pd, e, d, a, b;
      wait_ready();
      acc = cyc + 1;
      foreach (bank_d[i]) bank_d[i] = 0;
      pe = acc; pd = 0;
      for (int i = 0; i < len; i++) begin
         a = (start + i) % 1024;
         b = bank_of(m, a);
         e = (pe + 1 > bank_d[b] + 1) ? pe + 1 : bank_d[b] + 1;
         d = (e + 5 > pd + 1) ? e + 5 : pd + 1;
         bank_d[b] = d; pe = e; pd = d;
         expq.push_back('{d, 1'b1, mref[b][row_of(m, a)], m ? "R1 R4 read" : "R2 R4 read"});
      end
      ilv_mode = m; req_write = 0; req_addr = 10'(start); req_len = 3'(len - 1);
      req_valid = 1;
      @(negedge clk);
      req_valid = 0;
   endtask

   task automatic drain();
      while (expq.size() != 0) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (40000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int acc;
      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R11 ready after reset", req_ready, 1);
      chk("R11 strobe after reset", xfer_done, 0);
      run = 1;

      // fill memory in both mappings (R1, R2, R7)
      for (int i = 0; i < 16; i++) do_write(1, i, 16'h1000 + 16'(i));
      for (int i = 0; i < 8; i++) do_write(0, i, 16'h2000 + 16'(i));
      for (int i = 254; i < 258; i++) do_write(0, i, 16'h3000 + 16'(i));
      do_write(1, 1022, 16'h4AAA);
      do_write(1, 1023, 16'h4BBB);

      // R5: aligned interleaved burst of 8 overlaps banks
      do_read(1, 0, 8, acc); drain();
      chk("R5 interleaved burst end edge", last_done - acc, 15);

      // R6: linear burst of 8 serialises on one bank
      do_read(0, 0, 8, acc); drain();
      chk("R6 linear burst end edge", last_done - acc, 48);

      // R9: single word, length field 0
      do_read(1, 7, 1, acc); drain();
      chk("R9 single word end edge", last_done - acc, 6);

      // R4: unaligned interleaved start
      do_read(1, 2, 8, acc); drain();
      // R2/R6: linear burst crossing a bank boundary
      do_read(0, 254, 4, acc); drain();
      // R10: wrap past the top address
      do_read(1, 1022, 4, acc); drain();

      // R3: flip mode just after acceptance
      do_read(1, 8, 8, acc);
      ilv_mode = 0;
      req_addr = 10'd0; req_len = 3'd0;
      drain();

      // R8: request pulsed while busy is ignored
      do_read(1, 0, 8, acc);
      @(negedge clk);
      chk("R8 busy during burst", req_ready, 0);
      ilv_mode = 1; req_write = 1; req_addr = 10'd5; req_wdata = 16'hDEAD; req_valid = 1;
      @(negedge clk);
      req_valid = 0;
      drain();
      do_read(1, 5, 1, acc); drain();
      chk("R8 ready when idle", req_ready, 1);

      run = 0;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule